// File: doc/BRIEF.md
# Small-Page NAND Command Front End

This block is the device-side command and address front end of a small-page NAND memory. It watches an 8-bit input bus and takes a byte on each rising edge of the write strobe while chip enable is low. The command latch and address latch qualifiers decide whether that byte is a command, an address byte or a data byte. The block decodes command bytes and assembles a 10-bit column and a 15-bit row address over several address cycles. It then serves page data, status bytes or identification bytes on each falling edge of the read strobe. A ready output shows when an internal operation is running.

The page is 528 bytes long: 512 main bytes and 16 spare bytes. An 8-bit column byte can only reach part of that, so a column-area pointer, set by the read commands, picks the region the column byte indexes. The page buffer is held inside the block. The cell array and the program and erase engines are not modelled. An array operation is a fixed busy countdown, and when it ends the block samples a pass/fail input.

All strobes are sampled in the `clk` domain. A strobe edge is acted on at the clock edge where the new strobe level is first seen.

Top module: `nand_cmd_if`

## Requirements
- R1: After reset, `rdy` is 1, `io_oe` is 0, `io_out` is 00h, `row_addr` is 0 and the column pointer is area A.
- R2: Commands 00h, 01h and 50h select area A, B or C. The column byte then addresses page byte `col`, `256+col`, or `512+col[3:0]` respectively.
- R3: A read takes command plus three address cycles (column byte, row byte carrying row[7:0], row byte carrying row[14:8] in its low 7 bits). After the third address byte `rdy` goes low for exactly BUSY_CYCLES clock cycles, and `row_addr` shows the row. `rdy` only falls after an accepted write strobe.
- R4: Each read strobe falling edge in read-data state returns the next page byte, starting at the addressed column. At column 527 the pointer stays, so later strobes repeat byte 527.
- R5: An operation that used area C (read start or program confirm) returns the pointer to area A. Areas A and B stay selected across operations.
- R6: Program is 80h, three address cycles, data bytes, then 10h. 80h fills the whole buffer with FFh, so bytes that are not loaded read FFh. Data bytes are stored at sequential columns from the addressed column. 10h drops `rdy` for BUSY_CYCLES cycles.
- R7: Erase is 60h, two row bytes, then D0h. `rdy` drops for BUSY_CYCLES cycles. `row_addr` shows the row with bits [4:0] forced to 0 and bits [14:5] taken from the address.
- R8: After 70h, each read strobe returns status: bit 6 is `rdy`, bit 0 is the fail flag, and all other bits are 0. The fail flag is `op_fail` sampled as the last program or erase ends.
- R9: 90h followed by address byte 00h returns ECh on the first read strobe, then DEV_CODE (default 73h) on every later strobe.
- R10: Command FFh is accepted even while busy. It ends any operation, so `rdy` is 1 from the next cycle, and it sets area A and the idle state.
- R11: While `ce_n` is high, write and read strobes are ignored: no byte is stored, `io_out` holds its value and `io_oe` is 0.
- R12: While busy, every command other than 70h and FFh is ignored, including pointer commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Marks the written byte as a command |
| ale | input | 1 | Marks the written byte as an address byte |
| we_n | input | 1 | Write strobe; a byte is taken on its rising edge |
| re_n | input | 1 | Read strobe; the next byte is served on its falling edge |
| io_in | input | 8 | Byte bus into the block |
| op_fail | input | 1 | Pass (0) / fail (1) of the modelled array operation, sampled when it ends |
| io_out | output | 8 | Byte served to the bus |
| io_oe | output | 1 | Bus drive enable, high while chip enable and read strobe are both low |
| rdy | output | 1 | Ready (1) or busy (0) |
| row_addr | output | 15 | Row of the current or last array operation |

## Verification
The hardest situation to reach is the hand-back of the column pointer from area C to area A. The pointer is not visible at the ports. The bench therefore programs spare bytes through area C, reads them back through area C, and then issues a program with no pointer command. Where that byte lands shows which area was active. The same indirect method is used for pointer commands sent during a busy window and for the FFh abort: each is followed by a program whose landing column reveals the pointer. The end-of-page hold is reached through a column byte whose upper nibble area C must discard.

// File: rtl/nand_cmd_pkg.sv
package nand_cmd_pkg;

    localparam int PAGE_BYTES = 528;
    localparam int COL_W      = $clog2(PAGE_BYTES);
    localparam int ROW_W      = 15;
    localparam int BLK_LSB    = 5;

    localparam logic [7:0] C_RD_A    = 8'h00;
    localparam logic [7:0] C_RD_B    = 8'h01;
    localparam logic [7:0] C_RD_C    = 8'h50;
    localparam logic [7:0] C_PROG    = 8'h80;
    localparam logic [7:0] C_PROG_GO = 8'h10;
    localparam logic [7:0] C_ERASE   = 8'h60;
    localparam logic [7:0] C_ERS_GO  = 8'hD0;
    localparam logic [7:0] C_STATUS  = 8'h70;
    localparam logic [7:0] C_IDENT   = 8'h90;
    localparam logic [7:0] C_RESET   = 8'hFF;
    localparam logic [7:0] MAKER_ID  = 8'hEC;

    typedef enum logic [1:0] {AREA_A, AREA_B, AREA_C} area_e;

    typedef enum logic [3:0] {
        S_IDLE, S_RD_ADR, S_RD_DAT, S_PG_ADR, S_PG_DAT,
        S_ER_ADR, S_ID_ADR, S_ID_OUT, S_STAT
    } st_e;

    typedef struct packed {
        logic        wr;
        logic        rd;
    } strobe_t;

    function automatic logic [COL_W-1:0] col_base(area_e a, logic [7:0] b);
        case (a)
            AREA_B:  col_base = COL_W'({2'b01, b});
            AREA_C:  col_base = COL_W'({2'b10, 4'b0000, b[3:0]});
            default: col_base = COL_W'(b);
        endcase
    endfunction

    function automatic logic [7:0] status_byte(logic ready, logic fail);
        status_byte = {1'b0, ready, 5'b00000, fail};
    endfunction

endpackage

// File: rtl/nand_strobe_edge.sv
module nand_strobe_edge
    import nand_cmd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ce_n,
    input  logic    we_n,
    input  logic    re_n,
    output strobe_t stb
);
    logic we_d, re_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_d <= 1'b1;
            re_d <= 1'b1;
        end else begin
            we_d <= we_n;
            re_d <= re_n;
        end
    end

    assign stb.wr = !ce_n && we_n && !we_d;
    assign stb.rd = !ce_n && !re_n && re_d;
endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic abort,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || abort)      cnt <= '0;
        else if (start)        cnt <= CW'(CYCLES);
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1)) && !abort;
endmodule

// File: rtl/nand_page_buf.sv
module nand_page_buf #(
    parameter int DEPTH = 528,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fill,
    input  logic          wen,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || fill) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (wen && (int'(waddr) < DEPTH)) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = (int'(raddr) < DEPTH) ? mem[raddr] : 8'hFF;
endmodule

// File: rtl/nand_cmd_if.sv
module nand_cmd_if
    import nand_cmd_pkg::*;
#(
    parameter int         BUSY_CYCLES = 16,
    parameter logic [7:0] DEV_CODE    = 8'h73
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce_n,
    input  logic             cle,
    input  logic             ale,
    input  logic             we_n,
    input  logic             re_n,
    input  logic [7:0]       io_in,
    input  logic             op_fail,
    output logic [7:0]       io_out,
    output logic             io_oe,
    output logic             rdy,
    output logic [ROW_W-1:0] row_addr
);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_BYTES - 1);

    strobe_t          stb;
    st_e              state;
    area_e            area;
    logic [COL_W-1:0] ptr;
    logic [1:0]       acnt;
    logic [ROW_W-1:0] row_acc;
    logic             fail_q, pe_op, id_idx, busy, t_done;
    logic [7:0]       buf_rd;
    logic             go_prog, go_erase, go_read, rst_cmd, fill, buf_wen;
    logic [COL_W-1:0] ptr_nxt;

    nand_strobe_edge u_edge (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .re_n(re_n), .stb(stb)
    );

    assign rst_cmd  = stb.wr && cle && (io_in == C_RESET);
    assign go_prog  = stb.wr && cle && !busy && (io_in == C_PROG_GO) && (state == S_PG_DAT);
    assign go_erase = stb.wr && cle && !busy && (io_in == C_ERS_GO)
                      && (state == S_ER_ADR) && (acnt == 2'd2);
    assign go_read  = stb.wr && !cle && ale && !busy && (state == S_RD_ADR) && (acnt == 2'd2);
    assign fill     = stb.wr && cle && !busy && (io_in == C_PROG);
    assign buf_wen  = stb.wr && !cle && !ale && !busy && (state == S_PG_DAT);
    assign ptr_nxt  = (ptr == LAST_COL) ? ptr : ptr + 1'b1;

    nand_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .start(go_prog || go_erase || go_read),
        .abort(rst_cmd), .busy(busy), .done(t_done)
    );

    nand_page_buf #(.DEPTH(PAGE_BYTES), .AW(COL_W)) u_buf (
        .clk(clk), .rst(rst), .fill(fill), .wen(buf_wen),
        .waddr(ptr), .wdata(io_in), .raddr(ptr), .rdata(buf_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            area     <= AREA_A;
            ptr      <= '0;
            acnt     <= '0;
            row_acc  <= '0;
            row_addr <= '0;
            io_out   <= '0;
            fail_q   <= 1'b0;
            pe_op    <= 1'b0;
            id_idx   <= 1'b0;
        end else begin
            if (t_done && pe_op) fail_q <= op_fail;

            if (stb.wr && cle) begin
                if (io_in == C_RESET) begin
                    state <= S_IDLE;
                    area  <= AREA_A;
                end else if (io_in == C_STATUS) begin
                    state <= S_STAT;
                end else if (!busy) begin
                    case (io_in)
                        C_RD_A:   begin area <= AREA_A; state <= S_RD_ADR; acnt <= '0; end
                        C_RD_B:   begin area <= AREA_B; state <= S_RD_ADR; acnt <= '0; end
                        C_RD_C:   begin area <= AREA_C; state <= S_RD_ADR; acnt <= '0; end
                        C_PROG:   begin state <= S_PG_ADR; acnt <= '0; end
                        C_ERASE:  begin state <= S_ER_ADR; acnt <= '0; end
                        C_IDENT:  state <= S_ID_ADR;
                        C_PROG_GO: if (go_prog) begin
                            row_addr <= row_acc;
                            pe_op    <= 1'b1;
                            state    <= S_IDLE;
                            if (area == AREA_C) area <= AREA_A;
                        end
                        C_ERS_GO: if (go_erase) begin
                            row_addr <= {row_acc[ROW_W-1:BLK_LSB], BLK_LSB'(0)};
                            pe_op    <= 1'b1;
                            state    <= S_IDLE;
                        end
                        default: ;
                    endcase
                end
            end else if (stb.wr && ale) begin
                if (!busy) begin
                    case (state)
                        S_RD_ADR, S_PG_ADR: begin
                            case (acnt)
                                2'd0: ptr <= col_base(area, io_in);
                                2'd1: row_acc[7:0] <= io_in;
                                2'd2: row_acc[ROW_W-1:8] <= io_in[ROW_W-9:0];
                                default: ;
                            endcase
                            if (acnt != 2'd3) acnt <= acnt + 1'b1;
                            if (go_read) begin
                                state    <= S_RD_DAT;
                                row_addr <= {io_in[ROW_W-9:0], row_acc[7:0]};
                                pe_op    <= 1'b0;
                                if (area == AREA_C) area <= AREA_A;
                            end else if (state == S_PG_ADR && acnt == 2'd2) begin
                                state <= S_PG_DAT;
                            end
                        end
                        S_ER_ADR: begin
                            if (acnt == 2'd0) row_acc[7:0] <= io_in;
                            if (acnt == 2'd1) row_acc[ROW_W-1:8] <= io_in[ROW_W-9:0];
                            if (acnt < 2'd2) acnt <= acnt + 1'b1;
                        end
                        S_ID_ADR: begin
                            state  <= S_ID_OUT;
                            id_idx <= 1'b0;
                        end
                        default: ;
                    endcase
                end
            end else if (buf_wen) begin
                ptr <= ptr_nxt;
            end else if (stb.rd) begin
                case (state)
                    S_STAT: io_out <= status_byte(!busy, fail_q);
                    S_RD_DAT: if (!busy) begin
                        io_out <= buf_rd;
                        ptr    <= ptr_nxt;
                    end
                    S_ID_OUT: begin
                        io_out <= id_idx ? DEV_CODE : MAKER_ID;
                        id_idx <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rdy   = !busy;
    assign io_oe = !ce_n && !re_n;
endmodule

// File: rtl/nand_cmd_if_chk.sv
module nand_cmd_if_chk #(
    parameter int BUSY_CYCLES = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       ce_n,
    input logic       cle,
    input logic       we_n,
    input logic [7:0] io_in,
    input logic [7:0] io_out,
    input logic       rdy
);
    logic we_seen_d;
    int   low_run;
    logic wr_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_seen_d <= 1'b1;
            low_run   <= 0;
        end else begin
            we_seen_d <= we_n;
            low_run   <= rdy ? 0 : low_run + 1;
        end
    end

    assign wr_seen = !ce_n && we_n && !we_seen_d;

    // R3: a busy window never outlasts the configured count
    p_busy_bound_r3: assert property (@(posedge clk) disable iff (rst)
        low_run <= BUSY_CYCLES);

    // R3: ready only falls in response to an accepted write strobe
    p_fall_on_write_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(rdy) |-> $past(wr_seen));

    // R10: the reset command leaves the block ready on the next cycle
    p_reset_ready_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_seen && cle && io_in == 8'hFF) |=> rdy);

    // R11: a deselected block never changes the served byte
    p_ce_hold_r11: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> $stable(io_out));
endmodule

bind nand_cmd_if nand_cmd_if_chk #(.BUSY_CYCLES(BUSY_CYCLES)) chk_i (
    .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .we_n(we_n),
    .io_in(io_in), .io_out(io_out), .rdy(rdy)
);

// File: tb/nand_cmd_if_tb.sv
module nand_cmd_if_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BUSY       = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
    logic [7:0]  io_in = 8'h00;
    logic        op_fail = 1'b0;
    logic [7:0]  io_out;
    logic        io_oe, rdy;
    logic [14:0] row_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_cmd_if #(.BUSY_CYCLES(BUSY), .DEV_CODE(8'h73)) dut_i (
        .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
        .re_n(re_n), .io_in(io_in), .op_fail(op_fail), .io_out(io_out),
        .io_oe(io_oe), .rdy(rdy), .row_addr(row_addr)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic c, input logic a, input logic [7:0] d, input logic cen = 1'b0);
        @(negedge clk); ce_n = cen; cle = c; ale = a; io_in = d; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); cle = 1'b0; ale = 1'b0; ce_n = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] d);  bus_wr(1'b1, 1'b0, d); endtask
    task automatic adr(input logic [7:0] d);  bus_wr(1'b0, 1'b1, d); endtask
    task automatic dat(input logic [7:0] d);  bus_wr(1'b0, 1'b0, d); endtask

    task automatic rd(output logic [7:0] v);
        @(negedge clk); re_n = 1'b0;
        @(negedge clk); v = io_out; re_n = 1'b1;
    endtask

    task automatic wait_rdy(output int n);
        n = 0;
        while (!rdy && n < 1000) begin n++; @(negedge clk); end
    endtask

    task automatic addr3(input logic [7:0] c, input logic [7:0] r0, input logic [7:0] r1);
        adr(c); adr(r0); adr(r1);
    endtask

    task automatic read_start(input logic [7:0] pc, input logic [7:0] c,
                              input logic [7:0] r0, input logic [7:0] r1);
        int n;
        cmd(pc); addr3(c, r0, r1);
        wait_rdy(n);
    endtask

    task automatic t_reset;
        chk("R1 rdy", 16'(rdy), 16'h1);
        chk("R1 io_oe", 16'(io_oe), 16'h0);
        chk("R1 io_out", 16'(io_out), 16'h00);
        chk("R1 row_addr", 16'(row_addr), 16'h0);
    endtask

    task automatic t_prog_read_a;
        logic [7:0] v; int n;
        cmd(8'h80); addr3(8'd10, 8'h34, 8'h02);
        dat(8'hAA); dat(8'hBB); dat(8'hCC);
        cmd(8'h10);
        chk("R6 busy after confirm", 16'(rdy), 16'h0);
        wait_rdy(n);
        chk("R6 busy length", 16'(n), 16'(BUSY));
        cmd(8'h00); addr3(8'd9, 8'h34, 8'h02);
        chk("R3 busy after address", 16'(rdy), 16'h0);
        wait_rdy(n);
        chk("R3 busy length", 16'(n), 16'(BUSY));
        chk("R3 row_addr", 16'(row_addr), 16'h0234);
        rd(v); chk("R6 unloaded FF", 16'(v), 16'hFF);
        rd(v); chk("R4 byte0", 16'(v), 16'hAA);
        @(negedge clk); re_n = 1'b0; @(negedge clk);
        chk("R4 io_oe during read", 16'(io_oe), 16'h1);
        v = io_out; re_n = 1'b1;
        chk("R4 byte1", 16'(v), 16'hBB);
        rd(v); chk("R4 byte2", 16'(v), 16'hCC);
        rd(v); chk("R6 tail FF", 16'(v), 16'hFF);
    endtask

    task automatic t_area_b;
        logic [7:0] v; int n;
        read_start(8'h01, 8'd3, 8'h00, 8'h00);
        cmd(8'h80); addr3(8'd3, 8'h00, 8'h00); dat(8'h5A); cmd(8'h10); wait_rdy(n);
        read_start(8'h01, 8'd3, 8'h00, 8'h00);
        rd(v); chk("R2 R5 area B kept, byte 259", 16'(v), 16'h5A);
        read_start(8'h00, 8'd3, 8'h00, 8'h00);
        rd(v); chk("R2 area A byte 3", 16'(v), 16'hFF);
    endtask

    task automatic t_area_c;
        logic [7:0] v; int n;
        cmd(8'h50); cmd(8'h80); addr3(8'hFE, 8'h00, 8'h00);
        dat(8'h11); dat(8'h22); dat(8'h33); cmd(8'h10); wait_rdy(n);
        cmd(8'h50);
        read_start(8'h50, 8'hFE, 8'h00, 8'h00);
        rd(v); chk("R2 area C byte 526", 16'(v), 16'h11);
        rd(v); chk("R4 last column", 16'(v), 16'h33);
        rd(v); chk("R4 hold at 527", 16'(v), 16'h33);
        cmd(8'h80); addr3(8'd1, 8'h00, 8'h00); dat(8'h77); cmd(8'h10); wait_rdy(n);
        read_start(8'h00, 8'd0, 8'h00, 8'h00);
        rd(v); chk("R5 C reverted col0", 16'(v), 16'hFF);
        rd(v); chk("R5 C reverted col1", 16'(v), 16'h77);
    endtask

    task automatic t_erase_status;
        logic [7:0] v; int n;
        op_fail = 1'b1;
        cmd(8'h80); addr3(8'd0, 8'h00, 8'h00); dat(8'h01); cmd(8'h10);
        cmd(8'h70); rd(v);
        chk("R8 status while busy", 16'(v), 16'h00);
        wait_rdy(n);
        rd(v); chk("R8 status fail", 16'(v), 16'h41);
        op_fail = 1'b0;
        cmd(8'h60); adr(8'h3F); adr(8'h12); cmd(8'hD0);
        chk("R7 busy after erase", 16'(rdy), 16'h0);
        wait_rdy(n);
        chk("R7 busy length", 16'(n), 16'(BUSY));
        chk("R7 block row", 16'(row_addr), 16'h1220);
        cmd(8'h70); rd(v);
        chk("R8 status pass", 16'(v), 16'h40);
    endtask

    task automatic t_ident;
        logic [7:0] v;
        cmd(8'h90); adr(8'h00);
        rd(v); chk("R9 maker", 16'(v), 16'hEC);
        rd(v); chk("R9 device", 16'(v), 16'h73);
        rd(v); chk("R9 device again", 16'(v), 16'h73);
    endtask

    task automatic t_reset_cmd;
        logic [7:0] v; int n;
        cmd(8'h80); addr3(8'd0, 8'h00, 8'h00); cmd(8'h10);
        cmd(8'hFF);
        chk("R10 ready after FFh", 16'(rdy), 16'h1);
        cmd(8'h50); cmd(8'hFF);
        cmd(8'h80); addr3(8'd2, 8'h00, 8'h00); dat(8'h99); cmd(8'h10); wait_rdy(n);
        read_start(8'h00, 8'd2, 8'h00, 8'h00);
        rd(v); chk("R10 area A after FFh", 16'(v), 16'h99);
    endtask

    task automatic t_ce_high;
        logic [7:0] v, held; int n;
        cmd(8'h80); addr3(8'd0, 8'h00, 8'h00);
        dat(8'h44); bus_wr(1'b0, 1'b0, 8'h55, 1'b1); dat(8'h66); cmd(8'h10); wait_rdy(n);
        read_start(8'h00, 8'd0, 8'h00, 8'h00);
        rd(v); chk("R11 byte0", 16'(v), 16'h44);
        rd(v); chk("R11 ignored write", 16'(v), 16'h66);
        held = io_out;
        @(negedge clk); ce_n = 1'b1; re_n = 1'b0;
        @(negedge clk);
        chk("R11 io_oe low", 16'(io_oe), 16'h0);
        chk("R11 io_out held", 16'(io_out), 16'(held));
        re_n = 1'b1;
        @(negedge clk); ce_n = 1'b0;
        rd(v); chk("R11 pointer not moved", 16'(v), 16'hFF);
    endtask

    task automatic t_busy_ignore;
        logic [7:0] v; int n;
        cmd(8'h80); addr3(8'd0, 8'h00, 8'h00); cmd(8'h10);
        cmd(8'h01);
        chk("R12 still busy", 16'(rdy), 16'h0);
        wait_rdy(n);
        cmd(8'h80); addr3(8'd5, 8'h00, 8'h00); dat(8'h21); cmd(8'h10); wait_rdy(n);
        read_start(8'h00, 8'd5, 8'h00, 8'h00);
        rd(v); chk("R12 pointer unchanged", 16'(v), 16'h21);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0; ce_n = 1'b0;
        @(negedge clk);
        t_reset();
        t_prog_read_a();
        t_area_b();
        t_area_c();
        t_erase_status();
        t_ident();
        t_reset_cmd();
        t_ce_high();
        t_busy_ignore();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule